// File: doc/BRIEF.md
# Scaled Sprite Overlay Raster Generator

This block produces an 800x600, 60 Hz raster with horizontal and vertical sync and two bits each of red, green and blue. Internally the screen is a 100x75 grid of logical pixels, each covering an 8x8 block of screen pixels. One 12x12 sprite with two-bit pixel codes is drawn over one of four selectable background patterns. Colors come from a four-entry palette of 6-bit values.

A write-only serial port configures the block. It runs in SPI mode 0 and is sampled by the pixel clock. It loads the sprite position, the background choice, the palette and the sprite bitmap. At each line start the sprite row needed for the coming line is copied into a shift register. That register advances one logical pixel at a time, and only while the beam is inside the sprite's columns. The advance condition stands in for a gated clock.

A select input tells the block which pixel clock it runs on. With a 40 MHz clock the raster advances one screen pixel per cycle. With a 10 MHz clock it advances four screen pixels per cycle.

Top module: `sprite_raster_gen`

## Requirements
- R1: Each line has 1056 screen-pixel positions, the first 800 visible. Each frame has 628 lines, the first 600 visible. All color outputs are 0 outside the visible area.
- R2: `hsync_o` is high for positions 840 to 967 of each line. `vsync_o` is high for lines 601 to 604. Both are low elsewhere.
- R3: With `slow_clk_i` low the beam advances one screen pixel per clock, so the line is 1056 clocks and hsync first rises 840 clocks after reset. With `slow_clk_i` high it advances four screen pixels per clock, so the line is 264 clocks.
- R4: The logical column is position/8 and the logical row is line/8. The background codes are: 0 gives palette entry 0 everywhere; 1 gives palette entry 0 where bit 0 of column XOR bit 0 of row is 1; 2 gives it where bit 0 of the row is 1; 3 gives it where bit 0 of the column is 1. Every other background pixel is black.
- R5: The sprite covers columns ax..ax+11 and rows ay..ay+11. Pixel code 0 is transparent. Codes 1 to 3 show that palette entry. A palette entry is rrggbb in bits 5:0, with red in bits 5:4 and blue in bits 1:0.
- R6: Serial protocol: SPI mode 0, MSB first. The first byte after chip select falls is the address. Each later byte is written there, and the address then increments. Chip select high ends the transfer. The address map is: 0 sprite x, 1 sprite y, 2 background code (bits 1:0), 4 to 7 palette entries 0 to 3. Addresses 8 to 43 hold the bitmap: row r, byte k sits at address 8+3r+k. Pixel c of a row is bits 2c+1:2c of {byte2,byte1,byte0}. Other addresses are ignored.
- R7: A newly written x or y takes effect only at the start of the next line. The line in progress is drawn with the old position.
- R8: Written x values above 88 become 88, and written y values above 63 become 63.
- R9: The sprite shift register advances at most once per logical pixel. It advances only inside the sprite columns, at most 12 times per line, and is empty after the sprite.
- R10: After reset the counters sit at position 0 of line 0, all configuration is 0, both syncs are low and the color outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock (40 MHz or 10 MHz) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slow_clk_i | input | 1 | 1: clock is the slow one, four screen pixels per cycle |
| spi_sck_i | input | 1 | Serial clock of the configuration port |
| spi_cs_ni | input | 1 | Chip select, active low |
| spi_mosi_i | input | 1 | Serial data into the block |
| hsync_o | output | 1 | Horizontal sync, active high |
| vsync_o | output | 1 | Vertical sync, active high |
| red_o | output | 2 | Red channel |
| green_o | output | 2 | Green channel |
| blue_o | output | 2 | Blue channel |

## Verification
Several properties are checked on every cycle: colors stay black outside the visible window, hsync is high only in the horizontal blanking interval, and vsync changes only at a line start. The active position also holds still except at a line start, stays inside its clamp limits, and the sprite shift register never advances more than twelve times in a line. The bench's scenarios cover the rest. These are the decoding of the serial stream into registers, the exact color of chosen logical pixels under the checker and solid backgrounds, and a position change written mid-line while the sprite is on that line. They also cover clamping of out-of-range writes, the sync positions, and the line length in each clock mode.

// File: rtl/sprite_raster_gen.sv
module sprite_raster_gen #(
  parameter int H_VIS = 800,
  parameter int H_FP = 40,
  parameter int H_SYNC = 128,
  parameter int H_BP = 88,
  parameter int V_VIS = 600,
  parameter int V_FP = 1,
  parameter int V_SYNC = 4,
  parameter int V_BP = 23,
  parameter int SCALE_LOG2 = 3,
  parameter int GRID_W = 100,
  parameter int GRID_H = 75,
  parameter int SPR = 12,
  parameter int SLOW_STEP = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       slow_clk_i,
  input  logic       spi_sck_i,
  input  logic       spi_cs_ni,
  input  logic       spi_mosi_i,
  output logic       hsync_o,
  output logic       vsync_o,
  output logic [1:0] red_o,
  output logic [1:0] green_o,
  output logic [1:0] blue_o
);
  localparam int H_TOT = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int V_TOT = V_VIS + V_FP + V_SYNC + V_BP;
  localparam int HW = $clog2(H_TOT + SLOW_STEP);
  localparam int VW = $clog2(V_TOT);
  localparam int PW = HW - SCALE_LOG2;
  localparam int ROW_BITS = 2 * SPR;
  localparam int ROW_BYTES = ROW_BITS / 8;
  localparam int BM_BYTES = ROW_BYTES * SPR;
  localparam int BIW = $clog2(BM_BYTES);

  localparam logic [HW-1:0] H_TOT_C = HW'(H_TOT);
  localparam logic [HW-1:0] H_VIS_C = HW'(H_VIS);
  localparam logic [HW-1:0] HS_B = HW'(H_VIS + H_FP);
  localparam logic [HW-1:0] HS_E = HW'(H_VIS + H_FP + H_SYNC);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOT - 1);
  localparam logic [VW-1:0] V_VIS_C = VW'(V_VIS);
  localparam logic [VW-1:0] VS_B = VW'(V_VIS + V_FP);
  localparam logic [VW-1:0] VS_E = VW'(V_VIS + V_FP + V_SYNC);
  localparam logic [PW-1:0] SPR_C = PW'(SPR);
  localparam logic [PW-1:0] X_MAX_C = PW'(GRID_W - SPR);
  localparam logic [PW-1:0] Y_MAX_C = PW'(GRID_H - SPR);
  localparam logic [7:0] A_X = 8'd0;
  localparam logic [7:0] A_Y = 8'd1;
  localparam logic [7:0] A_BG = 8'd2;
  localparam logic [7:0] A_PAL = 8'd4;
  localparam logic [7:0] A_BM = 8'd8;
  localparam logic [7:0] A_BM_END = 8'(8 + BM_BYTES);

  // beam counters
  logic [HW-1:0] h, h_nxt;
  logic [VW-1:0] v, v_nxt;
  logic line_end;

  assign h_nxt = h + (slow_clk_i ? HW'(SLOW_STEP) : HW'(1));
  assign line_end = h_nxt >= H_TOT_C;
  assign v_nxt = (v == V_LAST) ? '0 : v + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h <= '0;
      v <= '0;
    end else if (line_end) begin
      h <= '0;
      v <= v_nxt;
    end else begin
      h <= h_nxt;
    end
  end

  // serial configuration port, oversampled by the pixel clock
  logic [2:0] sck_s;
  logic [1:0] cs_s, mosi_s;
  logic [2:0] bit_q;
  logic [6:0] sh_q;
  logic [7:0] addr_q, byte_v;
  logic addr_ok, spi_act, spi_rise, byte_done, wr;

  assign spi_act = ~cs_s[1];
  assign spi_rise = sck_s[1] & ~sck_s[2];
  assign byte_v = {sh_q, mosi_s[1]};
  assign byte_done = spi_act & spi_rise & (bit_q == 3'd7);
  assign wr = byte_done & addr_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_s <= '0;
      cs_s <= '1;
      mosi_s <= '0;
      bit_q <= '0;
      sh_q <= '0;
      addr_q <= '0;
      addr_ok <= 1'b0;
    end else begin
      sck_s <= {sck_s[1:0], spi_sck_i};
      cs_s <= {cs_s[0], spi_cs_ni};
      mosi_s <= {mosi_s[0], spi_mosi_i};
      if (!spi_act) begin
        bit_q <= '0;
        addr_ok <= 1'b0;
      end else if (spi_rise) begin
        bit_q <= bit_q + 1'b1;
        sh_q <= byte_v[6:0];
        if (bit_q == 3'd7) begin
          addr_q <= addr_ok ? addr_q + 1'b1 : byte_v;
          addr_ok <= 1'b1;
        end
      end
    end
  end

  // configuration registers
  logic [PW-1:0] px, py;
  logic [1:0] bgsel;
  logic [5:0] pal [4];
  logic [7:0] bm [BM_BYTES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      px <= '0;
      py <= '0;
      bgsel <= '0;
      pal <= '{default: '0};
      bm <= '{default: '0};
    end else if (wr) begin
      if (addr_q == A_X)
        px <= (PW'(byte_v) > X_MAX_C) ? X_MAX_C : PW'(byte_v);
      else if (addr_q == A_Y)
        py <= (PW'(byte_v) > Y_MAX_C) ? Y_MAX_C : PW'(byte_v);
      else if (addr_q == A_BG)
        bgsel <= byte_v[1:0];
      else if (addr_q >= A_PAL && addr_q < A_PAL + 8'd4)
        pal[addr_q[1:0]] <= byte_v[5:0];
      else if (addr_q >= A_BM && addr_q < A_BM_END)
        bm[BIW'(addr_q - A_BM)] <= byte_v;
    end
  end

  // sprite row fetch and shift register
  logic [PW-1:0] lx, ly, ly_n, row_idx, ax, ay;
  logic [ROW_BITS-1:0] sr, row_word;
  logic row_hit, in_cols, in_rows, pix_end, shift_en;

  assign lx = h[HW-1:SCALE_LOG2];
  assign ly = PW'(v >> SCALE_LOG2);
  assign ly_n = PW'(v_nxt >> SCALE_LOG2);
  assign row_hit = (ly_n >= py) && (ly_n < py + SPR_C);
  assign row_idx = ly_n - py;

  always_comb begin
    row_word = '0;
    if (row_hit)
      for (int k = 0; k < ROW_BYTES; k++)
        row_word[8*k +: 8] = bm[BIW'(row_idx * ROW_BYTES + k)];
  end

  assign in_cols = (lx >= ax) && (lx < ax + SPR_C);
  assign in_rows = (ly >= ay) && (ly < ay + SPR_C);
  assign pix_end = h_nxt[HW-1:SCALE_LOG2] != lx;
  assign shift_en = in_cols & pix_end & ~line_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ax <= '0;
      ay <= '0;
      sr <= '0;
    end else if (line_end) begin
      ax <= px;
      ay <= py;
      sr <= row_word;
    end else if (shift_en) begin
      sr <= sr >> 2;
    end
  end

  // color selection
  logic [1:0] code;
  logic bg_on, visible;
  logic [5:0] col;

  assign code = (in_cols && in_rows) ? sr[1:0] : 2'd0;

  always_comb begin
    case (bgsel)
      2'd0: bg_on = 1'b1;
      2'd1: bg_on = lx[0] ^ ly[0];
      2'd2: bg_on = ly[0];
      default: bg_on = lx[0];
    endcase
  end

  assign col = (code != 2'd0) ? pal[code] : (bg_on ? pal[0] : 6'd0);
  assign visible = (h < H_VIS_C) && (v < V_VIS_C);
  assign {red_o, green_o, blue_o} = visible ? col : 6'd0;
  assign hsync_o = (h >= HS_B) && (h < HS_E);
  assign vsync_o = (v >= VS_B) && (v < VS_E);
endmodule

// File: rtl/sprite_raster_gen_chk.sv
module sprite_raster_gen_chk #(
  parameter int H_VIS = 800,
  parameter int H_FP = 40,
  parameter int H_SYNC = 128,
  parameter int H_BP = 88,
  parameter int V_VIS = 600,
  parameter int V_FP = 1,
  parameter int V_SYNC = 4,
  parameter int V_BP = 23,
  parameter int SCALE_LOG2 = 3,
  parameter int GRID_W = 100,
  parameter int GRID_H = 75,
  parameter int SPR = 12,
  parameter int SLOW_STEP = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic [$clog2(H_VIS+H_FP+H_SYNC+H_BP+SLOW_STEP)-1:0] h,
  input logic [$clog2(V_VIS+V_FP+V_SYNC+V_BP)-1:0] v,
  input logic [$clog2(H_VIS+H_FP+H_SYNC+H_BP+SLOW_STEP)-SCALE_LOG2-1:0] ax,
  input logic [$clog2(H_VIS+H_FP+H_SYNC+H_BP+SLOW_STEP)-SCALE_LOG2-1:0] ay,
  input logic shift_en,
  input logic line_end,
  input logic hsync_o,
  input logic vsync_o,
  input logic [5:0] rgb
);
  localparam int HW = $clog2(H_VIS + H_FP + H_SYNC + H_BP + SLOW_STEP);
  localparam int VW = $clog2(V_VIS + V_FP + V_SYNC + V_BP);
  localparam int PW = HW - SCALE_LOG2;
  localparam logic [HW-1:0] H_VIS_C = HW'(H_VIS);
  localparam logic [VW-1:0] V_VIS_C = VW'(V_VIS);
  localparam logic [PW-1:0] X_MAX_C = PW'(GRID_W - SPR);
  localparam logic [PW-1:0] Y_MAX_C = PW'(GRID_H - SPR);
  localparam logic [5:0] SPR_C = 6'(SPR);

  logic [5:0] shifts;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) shifts <= '0;
    else if (line_end) shifts <= '0;
    else if (shift_en) shifts <= shifts + 1'b1;
  end

  a_r1_black_outside: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((h < H_VIS_C) && (v < V_VIS_C)) |-> rgb == 6'd0);
  a_r2_hsync_in_blank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hsync_o |-> h >= H_VIS_C);
  a_r2_vsync_at_line_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h != '0) |-> $stable(vsync_o));
  a_r7_pos_hold_midline: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h != '0) |-> ($stable(ax) && $stable(ay)));
  a_r8_pos_clamped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ax <= X_MAX_C) && (ay <= Y_MAX_C));
  a_r9_shift_budget: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shifts <= SPR_C);
endmodule

bind sprite_raster_gen sprite_raster_gen_chk #(
  .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
  .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
  .SCALE_LOG2(SCALE_LOG2), .GRID_W(GRID_W), .GRID_H(GRID_H),
  .SPR(SPR), .SLOW_STEP(SLOW_STEP)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .h(h), .v(v), .ax(ax), .ay(ay),
  .shift_en(shift_en), .line_end(line_end), .hsync_o(hsync_o),
  .vsync_o(vsync_o), .rgb({red_o, green_o, blue_o})
);

// File: tb/sprite_raster_gen_tb_top.sv
`timescale 1ns/1ps
module sprite_raster_gen_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, slow = 1'b1;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic hs, vs;
  logic [1:0] r, g, b;
  int n_cmp = 0, n_bad = 0;
  int bh, bv;

  always #2 clk = ~clk;

  sprite_raster_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .slow_clk_i(slow),
    .spi_sck_i(sck), .spi_cs_ni(cs_n), .spi_mosi_i(mosi),
    .hsync_o(hs), .vsync_o(vs), .red_o(r), .green_o(g), .blue_o(b)
  );

  // beam position from the R1/R3 timing figures
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bh <= 0;
      bv <= 0;
    end else if (bh + (slow ? 4 : 1) >= 1056) begin
      bh <= 0;
      bv <= (bv == 627) ? 0 : bv + 1;
    end else begin
      bh <= bh + (slow ? 4 : 1);
    end
  end

  // {line, position, rgb}; position = column*8+4
  localparam int NV = 12;
  localparam logic [26:0] VEC [NV] = '{
    {10'd23, 11'd652, 6'b000011},
    {10'd24, 11'd4,   6'b000011},
    {10'd24, 11'd644, 6'b000011},
    {10'd24, 11'd652, 6'b110000},
    {10'd24, 11'd796, 6'b000000},
    {10'd24, 11'd812, 6'b000000},
    {10'd31, 11'd660, 6'b001100},
    {10'd32, 11'd644, 6'b110000},
    {10'd40, 11'd636, 6'b000000},
    {10'd40, 11'd732, 6'b110000},
    {10'd40, 11'd740, 6'b000011},
    {10'd112, 11'd676, 6'b111111}
  };

  task automatic chk(string req, logic [10:0] act, logic [10:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s line %0d pos %0d: actual %0d expected %0d", req, bv, bh, act, exp);
    end
  endtask

  task automatic wait_pos(int line, int pos);
    while (!(bv == line && bh == pos)) @(negedge clk);
  endtask

  task automatic spi_byte(logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      mosi = d[i];
      repeat (2) @(negedge clk);
      sck = 1'b1;
      repeat (2) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  function automatic logic [7:0] bm_byte(int row, int k);
    logic [7:0] x;
    for (int j = 0; j < 4; j++) x[2*j +: 2] = 2'((row + 4*k + j) % 4);
    return x;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    chk("R10 rgb", {5'd0, r, g, b}, 11'd0);
    chk("R10 sync", {9'd0, hs, vs}, 11'd0);

    // R6: bg=1, skip 3, palette, 36 bitmap bytes in one burst
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
    spi_byte(8'd2);
    spi_byte(8'd1);
    spi_byte(8'd0);
    spi_byte(8'h03);
    spi_byte(8'h30);
    spi_byte(8'h0C);
    spi_byte(8'h3F);
    for (int row = 0; row < 12; row++)
      for (int k = 0; k < 3; k++) spi_byte(bm_byte(row, k));
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
    spi_byte(8'd0);
    spi_byte(8'd80);
    spi_byte(8'd3);
    repeat (2) @(negedge clk);
    cs_n = 1'b1;

    // R4 R5 R6 R9 pixel colors; R1 blank at 812
    for (int i = 0; i < NV; i++) begin
      wait_pos(int'(VEC[i][26:17]), int'(VEC[i][16:6]));
      chk("R4,R5,R6,R9 pixel", {5'd0, r, g, b}, {5'd0, VEC[i][5:0]});
    end

    // R7: move sprite mid-line while it is on this line; R8 x=200 clamps
    wait_pos(118, 0);
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
    spi_byte(8'd0);
    spi_byte(8'd200);
    spi_byte(8'd15);
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    wait_pos(118, 676);
    chk("R7 old position kept", {5'd0, r, g, b}, 11'b111111);
    wait_pos(119, 676);
    chk("R7 new position", {5'd0, r, g, b}, 11'd0);
    wait_pos(120, 700);
    chk("R8 left of clamped x", {5'd0, r, g, b}, 11'd0);
    wait_pos(120, 724);
    chk("R8 clamped x", {5'd0, r, g, b}, 11'b001100);
    wait_pos(120, 796);
    chk("R8 R9 last column", {5'd0, r, g, b}, 11'b111111);

    // R8 y=200 clamps to 63; bg=0 via auto-increment
    wait_pos(130, 0);
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
    spi_byte(8'd1);
    spi_byte(8'd200);
    spi_byte(8'd0);
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    wait_pos(503, 764);
    chk("R4 solid background", {5'd0, r, g, b}, 11'b000011);
    wait_pos(504, 700);
    chk("R4 solid left of sprite", {5'd0, r, g, b}, 11'b000011);
    wait_pos(504, 764);
    chk("R8 clamped y", {5'd0, r, g, b}, 11'b111111);
    wait_pos(504, 836);
    chk("R2 hsync before", {10'd0, hs}, 11'd0);
    wait_pos(504, 840);
    chk("R2 hsync start", {10'd0, hs}, 11'd1);
    wait_pos(504, 964);
    chk("R2 hsync end", {10'd0, hs}, 11'd1);
    wait_pos(504, 968);
    chk("R2 hsync after", {10'd0, hs}, 11'd0);
    wait_pos(600, 0);
    chk("R2 vsync before", {10'd0, vs}, 11'd0);
    chk("R1 blank line", {5'd0, r, g, b}, 11'd0);
    wait_pos(601, 0);
    chk("R2 vsync start", {10'd0, vs}, 11'd1);
    wait_pos(604, 1052);
    chk("R2 vsync end", {10'd0, vs}, 11'd1);
    wait_pos(605, 0);
    chk("R2 vsync after", {10'd0, vs}, 11'd0);

    // R3 fast clock, R10 reset again
    slow = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk("R10 rgb after reset", {5'd0, r, g, b}, 11'd0);
    chk("R10 sync after reset", {9'd0, hs, vs}, 11'd0);
    begin
      int n = 0;
      while (!hs && n < 5000) begin
        @(negedge clk);
        n++;
      end
      chk("R3 clocks to hsync", 11'(n), 11'd840);
      n = 0;
      while (hs && n < 5000) begin
        @(negedge clk);
        n++;
      end
      chk("R3 hsync width", 11'(n), 11'd128);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule